// File: doc/BRIEF.md
# Lockable Display Configuration Register Bank

This block holds three small configuration registers for a display subsystem. The first picks one screen or two. The second sets how the two pictures are placed and mixed. The third switches a clock output pin on or off. Software reaches them through a simple word-addressed bus with separate read and write strobes. A fourth address holds a guard register. That register takes exactly one write after reset, and its bits then stop writes to, or reads from, each of the three configuration registers for the rest of the reset period. Boot code usually fills the guard with all ones, which seals the bank completely.

The display register can also be changed by three debounced push-button pulses. Each pulse steps one field: window arrangement, blend ratio or main/sub role. The buttons work only while the register's key-lock bit is clear. They act whatever the guard register says, because the guard only restricts the bus. The current field values are always driven on dedicated output pins, so the video logic does not depend on bus reads.

Top module: `cfg_lock_bank`

## Requirements
- R1: After reset every configuration field, every output pin and `rd_data` are 0, and the guard register is empty.
- R2: The guard register (word address 0) stores only the first write it receives after reset, even if that write is 0x0000. Every later write to it is ignored until the next reset.
- R3: Guard bits 0, 1 and 2 block bus writes to the screen register (address 1), the display register (address 2) and the clock register (address 3) respectively. A blocked write leaves the register unchanged, and each bit affects only its own target.
- R4: Guard bits 8, 9 and 10 block bus reads of addresses 1, 2 and 3 respectively. A blocked read returns 0x0000 and does not change the register or its output pins.
- R5: A read of the guard register always returns 0x0000.
- R6: The display register layout is: window arrangement in bits 1:0, blend ratio in bits 5:4, TV source in bit 8, role swap in bit 9, TV enable in bit 14, key lock in bit 15. Each field drives its own output pin.
- R7: Bit 0 of the screen register drives `scr_single` (0 = dual screen, 1 = single screen). Bit 0 of the clock register drives `ck_out_en`.
- R8: Bits outside the defined fields ignore writes and read as 0 (the screen and clock registers read as 0x0000 or 0x0001, the display register is masked by 0xC333).
- R9: While key lock is 0, a `btn_win` or `btn_blend` pulse adds one to its 2-bit field, with 3 wrapping to 0, and a `btn_role` pulse toggles the role bit. This works even when the guard blocks bus writes to the display register.
- R10: While key lock is 1, button pulses change nothing.
- R11: If an accepted bus write to the display register and a button pulse arrive in the same cycle, the register takes the written value.
- R12: `rd_data` is registered. It shows the addressed word in the cycle after `rd_en` is high and is 0x0000 otherwise. Any address other than 0 to 3 reads as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| btn_win | input | 1 | Pulse: step window arrangement |
| btn_blend | input | 1 | Pulse: step blend ratio |
| btn_role | input | 1 | Pulse: toggle main/sub role |
| scr_single | output | 1 | Single-screen mode selected |
| ck_out_en | output | 1 | Clock output pin enable |
| win_mode | output | 2 | Window arrangement field |
| blend_sel | output | 2 | Blend ratio field |
| tv_src | output | 1 | TV source select |
| role_swap | output | 1 | Main/sub role swap |
| tv_en | output | 1 | TV output enable |
| key_lock | output | 1 | Buttons disabled |

## Verification
Checked on every cycle: once sealed, the guard never changes; a register that receives no accepted write stays stable; a button pulse under a clear key lock steps its field by one, while a set key lock freezes the display register; an accepted write beats a button; blocked reads, guard reads and idle cycles give zero; and no undefined bit ever appears on `rd_data`. Only the bench scenarios can show that the first guard write is the one kept, even when it is zero; that each guard bit hits its own target and no other; that button counts wrap correctly over many pulses; and that the pins follow the written values while reads are blocked.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  localparam int DATA_W   = 16;
  localparam int N_TGT    = 3;   // screen, display, clock
  localparam int RD_BASE  = 8;   // guard bit of first read-block
  localparam logic [DATA_W-1:0] DSW_MASK = 16'hC333;

  // target index used by the guard bit vectors
  localparam int T_SCR = 0;
  localparam int T_DSW = 1;
  localparam int T_CLK = 2;

  typedef struct packed {
    logic       key_lock;
    logic       tv_en;
    logic       role;
    logic       tv_src;
    logic [1:0] blend;
    logic [1:0] win;
  } dsw_t;

  function automatic logic [1:0] step2(input logic [1:0] v);
    return v + 2'd1;
  endfunction

  function automatic logic [DATA_W-1:0] dsw_pack(input dsw_t d);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[1:0]   = d.win;
    w[5:4]   = d.blend;
    w[8]     = d.tv_src;
    w[9]     = d.role;
    w[14]    = d.tv_en;
    w[15]    = d.key_lock;
    return w;
  endfunction

  function automatic dsw_t dsw_unpack(input logic [DATA_W-1:0] w);
    dsw_t d;
    d.win      = w[1:0];
    d.blend    = w[5:4];
    d.tv_src   = w[8];
    d.role     = w[9];
    d.tv_en    = w[14];
    d.key_lock = w[15];
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] bit_word(input logic b);
    return {{(DATA_W-1){1'b0}}, b};
  endfunction

endpackage

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [N_TGT-1:0] wr_blk_in,
  input  logic [N_TGT-1:0] rd_blk_in,
  output logic [N_TGT-1:0] wr_block,
  output logic [N_TGT-1:0] rd_block,
  output logic             sealed
);

  logic take;
  assign take = wr_hit && !sealed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sealed   <= 1'b0;
      wr_block <= '0;
      rd_block <= '0;
    end else if (take) begin
      sealed   <= 1'b1;
      wr_block <= wr_blk_in;
      rd_block <= rd_blk_in;
    end
  end

  AST_GUARD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |=> ($stable(wr_block) && $stable(rd_block))); // R2
  AST_GUARD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |=> sealed); // R2
  AST_GUARD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !sealed) |=> (wr_block == $past(wr_blk_in))); // R2

endmodule

// File: rtl/cfg_bit_reg.sv
module cfg_bit_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ok,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_ok) q <= wr_val;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(q)); // R3

endmodule

// File: rtl/cfg_dsw_reg.sv
module cfg_dsw_reg
  import cfg_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  dsw_t wr_val,
  input  logic btn_win,
  input  logic btn_blend,
  input  logic btn_role,
  output dsw_t q,
  output logic btn_live
);

  dsw_t nxt;

  assign btn_live = !q.key_lock && !wr_ok;

  always_comb begin
    nxt = q;
    if (wr_ok) begin
      nxt = wr_val;
    end else if (!q.key_lock) begin
      if (btn_win)   nxt.win   = step2(q.win);
      if (btn_blend) nxt.blend = step2(q.blend);
      if (btn_role)  nxt.role  = !q.role;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_KEYLOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (q.key_lock && !wr_ok) |=> $stable(q)); // R10
  AST_WIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_live && btn_win) |=> (q.win == 2'($past(q.win) + 2'd1))); // R9
  AST_BLEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_live && btn_blend) |=> (q.blend == 2'($past(q.blend) + 2'd1))); // R9
  AST_ROLE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_live && btn_role) |=> (q.role != $past(q.role))); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (q == $past(wr_val))); // R11

endmodule

// File: rtl/cfg_rd_path.sv
module cfg_rd_path
  import cfg_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [N_TGT:0]    hit,      // bit0 guard, bits 1..3 targets
  input  logic [N_TGT-1:0]  rd_block,
  input  logic              scr_q,
  input  dsw_t              dsw_q,
  input  logic              clk_q,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word [N_TGT];
  logic [DATA_W-1:0] sel;
  logic              blocked;

  assign word[T_SCR] = bit_word(scr_q);
  assign word[T_DSW] = dsw_pack(dsw_q);
  assign word[T_CLK] = bit_word(clk_q);

  assign blocked = |(hit[N_TGT:1] & rd_block);

  always_comb begin
    sel = '0;
    for (int t = 0; t < N_TGT; t++) begin
      if (hit[t+1] && !rd_block[t]) sel = sel | word[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= sel;
    else            rd_data <= '0;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0)); // R12
  AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && blocked) |=> (rd_data == '0)); // R4
  AST_GUARD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit[0]) |=> (rd_data == '0)); // R5
  AST_UNDEF_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~DSW_MASK) == '0); // R8
  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R12

endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] GUARD_ADDR = 0,
  parameter logic [ADDR_W-1:0] SCR_ADDR   = 1,
  parameter logic [ADDR_W-1:0] DSW_ADDR   = 2,
  parameter logic [ADDR_W-1:0] CLK_ADDR   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              btn_win,
  input  logic              btn_blend,
  input  logic              btn_role,
  output logic              scr_single,
  output logic              ck_out_en,
  output logic [1:0]        win_mode,
  output logic [1:0]        blend_sel,
  output logic              tv_src,
  output logic              role_swap,
  output logic              tv_en,
  output logic              key_lock
);

  localparam logic [ADDR_W-1:0] TGT_ADDR [N_TGT] = '{SCR_ADDR, DSW_ADDR, CLK_ADDR};

  logic [N_TGT:0]   hit;
  logic [N_TGT-1:0] wr_block, rd_block, wr_ok;
  logic             sealed, btn_live;
  logic             scr_q, clk_q;
  dsw_t             dsw_q, dsw_wr;
  logic             wr_data_unused;

  assign hit[0] = (addr == GUARD_ADDR);

  genvar t;
  generate
    for (t = 0; t < N_TGT; t++) begin : g_tgt
      assign hit[t+1] = (addr == TGT_ADDR[t]);
      assign wr_ok[t] = wr_en && hit[t+1] && !wr_block[t];
    end
  endgenerate

  assign dsw_wr = dsw_unpack(wr_data);
  assign wr_data_unused = &{1'b0, wr_data[13:11], wr_data[7:6], wr_data[3]};

  cfg_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_en && hit[0]),
    .wr_blk_in (wr_data[N_TGT-1:0]),
    .rd_blk_in (wr_data[RD_BASE+N_TGT-1:RD_BASE]),
    .wr_block  (wr_block),
    .rd_block  (rd_block),
    .sealed    (sealed)
  );

  cfg_bit_reg #(.W(1)) u_scr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ok  (wr_ok[T_SCR]),
    .wr_val (wr_data[0]),
    .q      (scr_q)
  );

  cfg_bit_reg #(.W(1)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ok  (wr_ok[T_CLK]),
    .wr_val (wr_data[0]),
    .q      (clk_q)
  );

  cfg_dsw_reg u_dsw (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_ok[T_DSW]),
    .wr_val    (dsw_wr),
    .btn_win   (btn_win),
    .btn_blend (btn_blend),
    .btn_role  (btn_role),
    .q         (dsw_q),
    .btn_live  (btn_live)
  );

  cfg_rd_path u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .hit      (hit),
    .rd_block (rd_block),
    .scr_q    (scr_q),
    .dsw_q    (dsw_q),
    .clk_q    (clk_q),
    .rd_data  (rd_data)
  );

  assign scr_single = scr_q;
  assign ck_out_en  = clk_q;
  assign win_mode   = dsw_q.win;
  assign blend_sel  = dsw_q.blend;
  assign tv_src     = dsw_q.tv_src;
  assign role_swap  = dsw_q.role;
  assign tv_en      = dsw_q.tv_en;
  assign key_lock   = dsw_q.key_lock;

  AST_SEALED_WRITE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed && wr_en && hit[T_SCR+1] && wr_block[T_SCR]) |=> $stable(scr_single)); // R3
  AST_BTN_IGNORED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (key_lock && !btn_live && !(wr_en && hit[T_DSW+1])) |=> $stable(win_mode)); // R10

endmodule

// File: tb/sim_cfg_lock_bank.sv
module sim_cfg_lock_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        btn_win = 1'b0, btn_blend = 1'b0, btn_role = 1'b0;
  logic        scr_single, ck_out_en, tv_src, role_swap, tv_en, key_lock;
  logic [1:0]  win_mode, blend_sel;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  cfg_lock_bank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .btn_win(btn_win), .btn_blend(btn_blend),
    .btn_role(btn_role), .scr_single(scr_single), .ck_out_en(ck_out_en),
    .win_mode(win_mode), .blend_sel(blend_sel), .tv_src(tv_src),
    .role_swap(role_swap), .tv_en(tv_en), .key_lock(key_lock)
  );

  // expected display word built from field values by arithmetic
  function automatic logic [15:0] dword(int w, int b, int ts, int rl, int te, int kl);
    return 16'(w + b * 16 + ts * 256 + rl * 512 + te * 16384 + kl * 32768);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read word one cycle after rd_en
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        #2;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R12 unexpected read act=%h exp=none", rd_data);
        end else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string tg = tag_q.pop_front();
          if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s read act=%h exp=%h", tg, rd_data, e);
          end
        end
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] exp, string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic press(bit w, bit b, bit r, int n);
    for (int i = 0; i < n; i++) begin
      btn_win = w; btn_blend = b; btn_role = r;
      @(negedge clk);
      btn_win = 1'b0; btn_blend = 1'b0; btn_role = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R12 missing reads act=%0d exp=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pins", {8'h0, scr_single, ck_out_en, win_mode, blend_sel, tv_src, role_swap}, 16'h0);
    chk("R1 pins2", {14'h0, tv_en, key_lock}, 16'h0);
    chk("R1 rd_data", rd_data, 16'h0);
    rd(4'd1, 16'h0, "R1 scr");
    rd(4'd2, 16'h0, "R1 dsw");
    rd(4'd3, 16'h0, "R1 clk");
    rd(4'd0, 16'h0, "R5 guard empty");

    // R7, R8 screen and clock registers
    wr(4'd1, 16'hFFFF);
    chk("R7 scr_single", {15'h0, scr_single}, 16'h1);
    rd(4'd1, 16'h0001, "R8 scr mask");
    wr(4'd3, 16'hFFFE);
    chk("R7 ck_out_en off", {15'h0, ck_out_en}, 16'h0);
    wr(4'd3, 16'h0001);
    chk("R7 ck_out_en on", {15'h0, ck_out_en}, 16'h1);

    // R6, R8 display layout
    wr(4'd2, 16'hFFFF);
    rd(4'd2, dword(3, 3, 1, 1, 1, 1), "R8 dsw mask");
    wr(4'd2, 16'h4100);
    chk("R6 tv pins", {13'h0, tv_src, tv_en, role_swap}, 16'h6);
    rd(4'd2, dword(0, 0, 1, 0, 1, 0), "R6 dsw layout");

    // R9 buttons
    wr(4'd2, 16'h0000);
    press(1, 0, 0, 5);
    rd(4'd2, dword(1, 0, 0, 0, 0, 0), "R9 win 5 steps");
    press(0, 1, 0, 3);
    chk("R9 blend pin", {14'h0, blend_sel}, 16'h3);
    press(0, 1, 0, 1);
    rd(4'd2, dword(1, 0, 0, 0, 0, 0), "R9 blend wrap");
    press(0, 0, 1, 1);
    rd(4'd2, dword(1, 0, 0, 1, 0, 0), "R9 role toggle");
    press(0, 0, 1, 1);
    chk("R9 role back", {15'h0, role_swap}, 16'h0);

    // R11 write beats button
    btn_win = 1'b1; btn_role = 1'b1;
    wr(4'd2, dword(2, 0, 0, 0, 0, 0));
    btn_win = 1'b0; btn_role = 1'b0;
    rd(4'd2, dword(2, 0, 0, 0, 0, 0), "R11 write wins");

    // R10 key lock
    wr(4'd2, dword(1, 2, 0, 0, 0, 1));
    press(1, 1, 1, 3);
    chk("R10 pins frozen", {12'h0, win_mode, blend_sel}, 16'h6);
    rd(4'd2, dword(1, 2, 0, 0, 0, 1), "R10 frozen");

    // R12 unused address, idle read data
    rd(4'd7, 16'h0, "R12 bad address");
    @(negedge clk);
    chk("R12 idle zero", rd_data, 16'h0);

    // R3 R4 R5 partial guard: block dsw writes, scr reads
    wr(4'd2, 16'h4100);
    wr(4'd0, 16'h0102);
    wr(4'd2, 16'h0000);
    rd(4'd2, dword(0, 0, 1, 0, 1, 0), "R3 dsw write blocked");
    rd(4'd1, 16'h0, "R4 scr read blocked");
    chk("R4 scr pin kept", {15'h0, scr_single}, 16'h1);
    wr(4'd1, 16'h0000);
    chk("R3 scr still writable", {15'h0, scr_single}, 16'h0);
    rd(4'd0, 16'h0, "R5 guard reads zero");
    wr(4'd0, 16'hFFFF);
    wr(4'd3, 16'h0000);
    chk("R2 second guard write ignored", {15'h0, ck_out_en}, 16'h0);
    rd(4'd3, 16'h0, "R2 clk read open");
    wr(4'd3, 16'h0001);
    rd(4'd3, 16'h0001, "R2 clk read open");
    press(1, 0, 0, 1);
    rd(4'd2, dword(1, 0, 1, 0, 1, 0), "R9 buttons under write guard");

    // R2 zero guard write is final
    do_reset();
    wr(4'd0, 16'h0000);
    wr(4'd0, 16'hFFFF);
    wr(4'd2, 16'h8003);
    rd(4'd2, dword(3, 0, 0, 0, 0, 1), "R2 zero guard kept");
    wr(4'd1, 16'h0001);
    chk("R2 scr writable", {15'h0, scr_single}, 16'h1);

    // R3 R4 full seal
    do_reset();
    wr(4'd0, 16'hFFFF);
    wr(4'd1, 16'h0001);
    wr(4'd2, 16'hFFFF);
    wr(4'd3, 16'h0001);
    chk("R3 sealed pins", {13'h0, scr_single, ck_out_en, key_lock}, 16'h0);
    rd(4'd1, 16'h0, "R4 sealed scr");
    rd(4'd2, 16'h0, "R4 sealed dsw");
    rd(4'd3, 16'h0, "R4 sealed clk");
    press(1, 0, 0, 1);
    chk("R9 sealed buttons", {14'h0, win_mode}, 16'h1);
    rd(4'd2, 16'h0, "R4 sealed dsw after btn");

    done = 1'b1;
    finish_run();
  end

endmodule